// File: doc/BRIEF.md
# Task-Driven Compare Timer

This block is a free-running up-counter with four compare channels. Software drives it with one-shot command writes (run, halt, zero) instead of a control bit field. Each channel holds a compare value. When the counter steps onto that value, the channel raises a flag. The flag stays raised until software writes zero to it. A mask selects which flags drive a single level interrupt line.

The counter advances on `tick_i` pulses. A prescaler divides them by a power of two. The counter width can be 8, 16, 24 or 32 bits, and it wraps to zero at the top of the chosen width. A compare value the counter has already passed fires only after the counter wraps and climbs back to it. All registers are reached through a simple word-addressed write strobe and a combinational read port.

Top module: `task_timer`

## Requirements
- R1: After reset the counter is stopped at 0. All flags, the interrupt mask, the width mode, the prescaler and every compare value are 0, and `irq_o` is low.
- R2: A write with `wdata_i[0]`=1 to word 0 starts the counter, to word 1 stops it, and to word 2 zeroes the counter and the prescale divider. The command takes effect at the clock edge of the write. While the block is running, the counter advances at each later edge. While it is stopped, the counter holds its value. Zeroing takes precedence over an advance in the same cycle. A command write with `wdata_i[0]`=0 has no effect.
- R3: With prescaler value P (word 9, 4 bits), the counter advances once every 2^P edges on which `tick_i` is high. Edges with `tick_i` low make no progress.
- R4: The width mode (word 8, 2 bits) selects 0=16-bit, 1=8-bit, 2=24-bit and 3=32-bit. The counter wraps from the all-ones value of that width to 0.
- R5: Flag n (word 4+n) is set at the edge where the counter steps onto the compare value n (word 12+n). A compare value that is already behind the counter fires only after a wrap. A compare value above the selected width never fires.
- R6: A flag stays set through further counting and wraps. Writing 0 to it clears it, and writing a nonzero value leaves it unchanged. A match in the same cycle as a clearing write leaves the flag set.
- R7: Writes to the width mode and prescaler words are ignored while the counter is running.
- R8: Writing a bit mask to word 10 sets mask bits, and writing one to word 11 clears mask bits. Both words read back the mask. `irq_o` is high exactly when some flag and its mask bit are both set.
- R9: Reads return flags in bit 0, mode, prescaler, mask and compare values right-aligned. The command words read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Base count enable, one pulse per base period |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Level interrupt: masked OR of the flags |

## Verification
The bench builds the block with its default parameters: four channels, a 4-bit prescaler and a 5-bit address. In 16-bit mode a full wrap costs only 65,536 cycles. That puts a late-written compare value that has to wait for the wrap within reach. The 8-bit mode gives many quick wraps, which exercise a match that coincides with a clearing write. Prescaler 2 combined with a gated `tick_i` shows the divide-by-four step. The 24- and 32-bit wraps are too long to run, so they are covered only by mode readback and by the masked wrap logic they share with the other modes.

// File: rtl/task_timer.sv
module task_timer #(
  parameter int NUM_CC = 4,
  parameter int PRE_W  = 4,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);

  localparam int DIV_W   = (1 << PRE_W) - 1;
  localparam int START_A = 0;
  localparam int STOP_A  = 1;
  localparam int CLR_A   = 2;
  localparam int EVT_A   = 4;
  localparam int MODE_A  = EVT_A + NUM_CC;
  localparam int PRE_A   = MODE_A + 1;
  localparam int MSET_A  = PRE_A + 1;
  localparam int MCLR_A  = MSET_A + 1;
  localparam int CC_A    = MCLR_A + 1;

  logic              run_q;
  logic [31:0]       cnt_q;
  logic [1:0]        mode_q;
  logic [PRE_W-1:0]  pre_q;
  logic [DIV_W-1:0]  div_q;
  logic [NUM_CC-1:0] evt_q, mask_q, evt_clr, hit;
  logic [31:0]       cc_q [NUM_CC];
  logic [31:0]       wmask, cnt_nx;
  logic [DIV_W-1:0]  dmask;
  logic              t_start, t_stop, t_clr, step;

  assign t_start = wr_i && addr_i == ADDR_W'(START_A) && wdata_i[0];
  assign t_stop  = wr_i && addr_i == ADDR_W'(STOP_A)  && wdata_i[0];
  assign t_clr   = wr_i && addr_i == ADDR_W'(CLR_A)   && wdata_i[0];

  always_comb begin
    case (mode_q)
      2'd0:    wmask = 32'h0000_FFFF;
      2'd1:    wmask = 32'h0000_00FF;
      2'd2:    wmask = 32'h00FF_FFFF;
      default: wmask = 32'hFFFF_FFFF;
    endcase
  end

  assign dmask  = (DIV_W'(1) << pre_q) - DIV_W'(1);
  assign step   = run_q && tick_i && ((div_q & dmask) == dmask);
  assign cnt_nx = (cnt_q + 32'd1) & wmask;
  assign irq_o  = |(evt_q & mask_q);

  always_comb begin
    for (int n = 0; n < NUM_CC; n++) begin
      evt_clr[n] = wr_i && addr_i == ADDR_W'(EVT_A + n) && wdata_i == 32'd0;
      hit[n]     = step && !t_clr && cnt_nx == cc_q[n];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      div_q  <= '0;
      mode_q <= '0;
      pre_q  <= '0;
      mask_q <= '0;
      evt_q  <= '0;
      for (int n = 0; n < NUM_CC; n++) cc_q[n] <= '0;
    end else begin
      if (t_start) run_q <= 1'b1;
      if (t_stop)  run_q <= 1'b0;
      if (t_clr) begin
        cnt_q <= '0;
        div_q <= '0;
      end else if (run_q && tick_i) begin
        div_q <= div_q + DIV_W'(1);
        if (step) cnt_q <= cnt_nx;
      end
      if (wr_i && !run_q && addr_i == ADDR_W'(MODE_A)) mode_q <= wdata_i[1:0];
      if (wr_i && !run_q && addr_i == ADDR_W'(PRE_A))  pre_q  <= wdata_i[PRE_W-1:0];
      if (wr_i && addr_i == ADDR_W'(MSET_A)) mask_q <= mask_q | wdata_i[NUM_CC-1:0];
      if (wr_i && addr_i == ADDR_W'(MCLR_A)) mask_q <= mask_q & ~wdata_i[NUM_CC-1:0];
      for (int n = 0; n < NUM_CC; n++)
        if (wr_i && addr_i == ADDR_W'(CC_A + n)) cc_q[n] <= wdata_i;
      evt_q <= (evt_q & ~evt_clr) | hit;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(MODE_A)) rdata_o = {30'd0, mode_q};
    if (addr_i == ADDR_W'(PRE_A))  rdata_o = {{(32-PRE_W){1'b0}}, pre_q};
    if (addr_i == ADDR_W'(MSET_A) || addr_i == ADDR_W'(MCLR_A))
      rdata_o = {{(32-NUM_CC){1'b0}}, mask_q};
    for (int n = 0; n < NUM_CC; n++) begin
      if (addr_i == ADDR_W'(EVT_A + n)) rdata_o = {31'd0, evt_q[n]};
      if (addr_i == ADDR_W'(CC_A + n))  rdata_o = cc_q[n];
    end
  end

  // R2
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !t_clr) |=> $stable(cnt_q));

  // R3
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !t_clr) |=> $stable(cnt_q));

  // R4
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !t_clr && cnt_q == wmask) |=> cnt_q == 32'd0);

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(evt_q) & ~$past(evt_clr) & ~evt_q) == '0));

  // R7
  mode_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && wr_i && addr_i == ADDR_W'(MODE_A)) |=> $stable(mode_q));

  // R8
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (evt_q != '0 && mask_q != '0));

endmodule

// File: tb/tb_task_timer.sv
module tb_task_timer;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b1;
  logic        wr_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;
  int total = 0;
  int bad = 0;

  task_timer dut (.clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_i(wr_i),
                  .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    wr_i = 1'b1; addr_i = a[4:0]; wdata_i = d;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic rdchk(input string req, input int a, input logic [31:0] exp);
    addr_i = a[4:0];
    #1;
    chk(req, rdata_o, exp);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    for (int n = 0; n < 16; n++) rdchk("R1/R9 reset read", n, 32'd0);
    chk("R1 irq", {31'd0, irq_o}, 32'd0);
  endtask

  task automatic t_wide_wrap;
    wr(8, 0); wr(9, 0);
    wr(12, 2); wr(13, 162); wr(14, 480);
    wr(0, 1);
    step(160);
    rdchk("R5 cc0 swept", 4, 1); rdchk("R5 cc1 not yet", 5, 0);
    wr(15, 114);
    step(159);
    rdchk("R5 cc1 reached", 5, 1); rdchk("R5 cc2 early", 6, 0);
    step(159);
    rdchk("R5 cc2 one short", 6, 0);
    step(1);
    rdchk("R5 cc2 exact", 6, 1); rdchk("R5 cc3 behind", 7, 0);
    step(65169);
    rdchk("R4 cc3 before wrap reach", 7, 0);
    step(1);
    rdchk("R4 cc3 after wrap", 7, 1);
    rdchk("R6 cc0 sticky", 4, 1);
    wr(4, 32'h1);
    rdchk("R6 nonzero write keeps", 4, 1);
    wr(10, 32'h4);
    rdchk("R8 mask read", 11, 4);
    chk("R8 irq on", {31'd0, irq_o}, 1);
    wr(11, 32'h4);
    chk("R8 irq masked off", {31'd0, irq_o}, 0);
    wr(10, 32'h1);
    chk("R8 irq via cc0", {31'd0, irq_o}, 1);
    for (int n = 0; n < 4; n++) wr(4 + n, 0);
    for (int n = 0; n < 4; n++) rdchk("R6 zero write clears", 4 + n, 0);
    chk("R8 irq after clear", {31'd0, irq_o}, 0);
    wr(11, 32'hF);
  endtask

  task automatic t_narrow;
    wr(1, 1); wr(8, 1); wr(2, 1);
    for (int n = 0; n < 4; n++) wr(4 + n, 0);
    wr(12, 32'h105); wr(13, 5); wr(14, 5);
    wr(0, 1);
    step(5);
    rdchk("R5 8-bit match", 5, 1);
    wr(5, 0);
    step(254);
    rdchk("R4 8-bit wrapped not yet", 5, 0);
    rdchk("R6 cc2 kept", 6, 1);
    wr(6, 0);
    rdchk("R4 8-bit after wrap", 5, 1);
    rdchk("R6 match beats clear", 6, 1);
    rdchk("R5 above width never", 4, 0);
  endtask

  task automatic t_prescale;
    wr(1, 1); wr(9, 2); wr(2, 1);
    wr(12, 3); wr(4, 0);
    rdchk("R3 prescaler read", 9, 2);
    wr(0, 1);
    tick_i = 1'b0;
    step(5);
    tick_i = 1'b1;
    step(11);
    rdchk("R3 one tick short", 4, 0);
    step(1);
    rdchk("R3 divided match", 4, 1);
  endtask

  task automatic t_stop_clear;
    wr(1, 1); wr(9, 0); wr(2, 1);
    wr(4, 0); wr(12, 10);
    wr(0, 1);
    step(5);
    wr(1, 1);
    wr(0, 0);
    step(50);
    rdchk("R2 stopped holds", 4, 0);
    wr(0, 1);
    step(3);
    rdchk("R2 resumed short", 4, 0);
    step(1);
    rdchk("R2 resumed match", 4, 1);
    wr(8, 3);
    rdchk("R7 mode locked", 8, 1);
    wr(9, 5);
    rdchk("R7 prescaler locked", 9, 0);
    wr(4, 0);
    wr(2, 1);
    step(9);
    rdchk("R2 clear restarts short", 4, 0);
    step(1);
    rdchk("R2 clear restarts match", 4, 1);
    wr(1, 1);
    wr(8, 2);
    rdchk("R4 24-bit mode read", 8, 2);
    rdchk("R9 task word reads 0", 0, 0);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_wide_wrap();
    t_narrow();
    t_prescale();
    t_stop_clear();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule